// File: doc/BRIEF.md
# Alternating Step Keystream Generator

This block produces a pseudo-random keystream one bit at a time. It uses three linear feedback shift registers of distinct lengths. A short control register advances on every enabled step. The bit it presents before that step decides which of two longer data registers moves on the step: the first data register when the bit is 1, the second when it is 0. The keystream bit is the XOR of the low bits of the two data registers. Because each data register is clocked irregularly, the combined sequence is far harder to predict than either register alone.

A host seeds all three registers at once with a load strobe and then raises the step enable for as many cycles as it needs bits. A seed of all zeros would lock a register at zero for good. Any such seed is therefore replaced with the value 1, and a one-cycle error flag is raised. The feedback polynomials are fixed when the block is elaborated. The defaults are x^5+x^3+1 for control, x^7+x^6+1 for the first data register and x^11+x^9+1 for the second, which give periods of 31, 127 and 2047.

Top module: `altstep_keygen`

## Requirements
- R1: While rst_n is low at a clock edge, all three registers become 1 and key_vld_o and seed_err_o become 0. Directly after reset, key_o is therefore 0.
- R2: A load_i edge copies each seed into its register. Load takes priority over step_i. In the cycle after a load, key_vld_o is 0 and key_o equals seed_a_i[0] XOR seed_b_i[0].
- R3: A zero seed on any register puts the value 1 in that register. When at least one seed is zero, seed_err_o is 1 for exactly the one cycle after that load edge; otherwise seed_err_o stays 0.
- R4: On each enabled step (step_i=1, load_i=0), the control register shifts right by one. Bit 0 XOR bit 3 of the old value enters at bit 4.
- R5: The first data register (7 bits) shifts only on steps where control bit 0 before the shift is 1. Its new bit 6 is old bit 0 XOR old bit 6.
- R6: The second data register (11 bits) shifts only on steps where control bit 0 before the shift is 0. Its new bit 10 is old bit 0 XOR old bit 9.
- R7: key_o is bit 0 of the first data register XOR bit 0 of the second, taken after the step's shift.
- R8: key_vld_o is 1 for exactly the one cycle after each enabled step and 0 in every other cycle.
- R9: With step_i and load_i both low, no register changes, so key_o holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | Seed load strobe |
| seed_ctl_i | input | 5 | Seed for the control register |
| seed_a_i | input | 7 | Seed for the first data register |
| seed_b_i | input | 11 | Seed for the second data register |
| step_i | input | 1 | Advance the generator by one step |
| key_o | output | 1 | Keystream bit |
| key_vld_o | output | 1 | key_o holds a fresh bit from the last step |
| seed_err_o | output | 1 | The last load carried an all-zero seed |

## Verification
The bench sweeps every nonzero control seed, and then a wide range of data seeds. Each run is compared bit by bit over many steps against an arithmetic model. A design that sampled the control bit after its shift, or that swapped which data register follows a 1, drifts from the model within a few steps. It also loads every combination of zero seeds: a design that failed to substitute 1 would emit a stuck stream, and one that held the error flag would show it in the following cycle. Idle cycles between steps catch a valid flag that lingers, and loads issued together with a step catch a design that lets the step win.

// File: rtl/altstep_pkg.sv
// Package: shared lengths and tap positions for the alternating step generator.
// Assumes each polynomial is a trinomial x^W + x^K + 1 that is primitive.
package altstep_pkg;

    localparam int unsigned CTL_W = 5;
    localparam int unsigned CTL_K = 3;
    localparam int unsigned DA_W  = 7;
    localparam int unsigned DA_K  = 6;
    localparam int unsigned DB_W  = 11;
    localparam int unsigned DB_K  = 9;

    // Build a tap mask for bit 0 and bit k (feedback = XOR of masked bits).
    function automatic logic [31:0] tap_mask(input int unsigned k);
        logic [31:0] m;
        m = '0;
        for (int i = 0; i < 32; i++) begin
            if (i == 0 || i == int'(k)) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/altstep_seed_fix.sv
// Seed guard: passes a seed through, or substitutes 1 when it is all zeros.
// Assumes nothing about the seed; purely combinational.
module altstep_seed_fix #(
    parameter int unsigned W = 5
) (
    input  logic [W-1:0] seed_i,
    output logic [W-1:0] seed_o,
    output logic         zero_o
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    // Detect a locking seed and replace it.
    always_comb begin
        zero_o = (seed_i == '0);
        seed_o = zero_o ? ONE : seed_i;
    end

endmodule

// File: rtl/altstep_lfsr.sv
// Fibonacci shift register: shifts right, feedback enters at the MSB, output is bit 0.
// Assumes TAPS holds bit 0 and the second tap of a primitive trinomial.
// Load has priority over advance; reset value is 1.
module altstep_lfsr #(
    parameter int unsigned W    = 5,
    parameter int unsigned K    = 3,
    parameter logic [31:0] TAPS = 32'h9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] seed_i,
    input  logic         adv_i,
    output logic         out_o,
    output logic [W-1:0] state_o,
    output logic         seed_zero_o
);

    localparam logic [W-1:0] RST_VAL = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] MASK    = TAPS[W-1:0];

    logic [W-1:0] state_q;
    logic [W-1:0] seed_ok;
    logic         fb;

    altstep_seed_fix #(.W(W)) u_fix (
        .seed_i (seed_i),
        .seed_o (seed_ok),
        .zero_o (seed_zero_o)
    );

    // Feedback bit: parity of the tapped bits.
    always_comb fb = ^(state_q & MASK);

    // State register: reset, load a guarded seed, or shift one place.
    always_ff @(posedge clk) begin
        if (!rst_n)      state_q <= RST_VAL;
        else if (load_i) state_q <= seed_ok;
        else if (adv_i)  state_q <= {fb, state_q[W-1:1]};
    end

    assign out_o   = state_q[0];
    assign state_o = state_q;

    // R3: a register never reaches the locked all-zero state.
    a_r3_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);

    // R9: without load or advance the register keeps its value.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adv_i) |=> $stable(state_q));

    // R4: an advance moves old bit 1 down to bit 0.
    a_r4_shift_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && adv_i) |=> (state_q[0] == $past(state_q[1])));

endmodule

// File: rtl/altstep_step_ctrl.sv
// Step controller: turns step/load and the control bit into per-register advances,
// and registers the valid and seed-error flags.
// Assumes ctl_bit_i is the control register output before the current edge.
module altstep_step_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic step_i,
    input  logic ctl_bit_i,
    input  logic seed_zero_i,
    output logic ctl_adv_o,
    output logic a_adv_o,
    output logic b_adv_o,
    output logic vld_o,
    output logic err_o
);

    logic go;
    logic vld_q;
    logic err_q;

    // Advance selection: control always, one data register per step.
    always_comb begin
        go        = step_i && !load_i;
        ctl_adv_o = go;
        a_adv_o   = go &&  ctl_bit_i;
        b_adv_o   = go && !ctl_bit_i;
    end

    // Flag registers: valid after a step, error after a load with a zero seed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            vld_q <= go;
            err_q <= load_i && seed_zero_i;
        end
    end

    assign vld_o = vld_q;
    assign err_o = err_q;

    // R8: valid is only seen after an enabled step.
    a_r8_vld_cause: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |-> ($past(step_i) && !$past(load_i)));

    // R3: the error flag only follows a load.
    a_r3_err_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> $past(load_i));

    // R2: a load never produces a valid bit.
    a_r2_load_no_vld: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> !vld_q);

endmodule

// File: rtl/altstep_keygen.sv
// Alternating step keystream generator top.
// A control register picks, each step, which of two data registers advances;
// the keystream bit is the XOR of the two data registers' low bits.
// Assumes the three lengths differ and all polynomials are primitive.
module altstep_keygen
    import altstep_pkg::*;
#(
    parameter int unsigned C_W = CTL_W,
    parameter int unsigned C_K = CTL_K,
    parameter int unsigned A_W = DA_W,
    parameter int unsigned A_K = DA_K,
    parameter int unsigned B_W = DB_W,
    parameter int unsigned B_K = DB_K
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_i,
    input  logic [C_W-1:0] seed_ctl_i,
    input  logic [A_W-1:0] seed_a_i,
    input  logic [B_W-1:0] seed_b_i,
    input  logic           step_i,
    output logic           key_o,
    output logic           key_vld_o,
    output logic           seed_err_o
);

    localparam logic [31:0] C_TAPS = tap_mask(C_K);
    localparam logic [31:0] A_TAPS = tap_mask(A_K);
    localparam logic [31:0] B_TAPS = tap_mask(B_K);

    logic           ctl_bit, a_bit, b_bit;
    logic [C_W-1:0] ctl_state;
    logic [A_W-1:0] a_state;
    logic [B_W-1:0] b_state;
    logic           ctl_zero, a_zero, b_zero;
    logic           ctl_adv, a_adv, b_adv;
    logic           any_zero;

    altstep_lfsr #(.W(C_W), .K(C_K), .TAPS(C_TAPS)) u_ctl (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .seed_i(seed_ctl_i),
        .adv_i(ctl_adv), .out_o(ctl_bit), .state_o(ctl_state), .seed_zero_o(ctl_zero)
    );

    altstep_lfsr #(.W(A_W), .K(A_K), .TAPS(A_TAPS)) u_da (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .seed_i(seed_a_i),
        .adv_i(a_adv), .out_o(a_bit), .state_o(a_state), .seed_zero_o(a_zero)
    );

    altstep_lfsr #(.W(B_W), .K(B_K), .TAPS(B_TAPS)) u_db (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .seed_i(seed_b_i),
        .adv_i(b_adv), .out_o(b_bit), .state_o(b_state), .seed_zero_o(b_zero)
    );

    // Combine zero-seed detections from all three guards.
    always_comb any_zero = ctl_zero | a_zero | b_zero;

    altstep_step_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .step_i(step_i),
        .ctl_bit_i(ctl_bit), .seed_zero_i(any_zero),
        .ctl_adv_o(ctl_adv), .a_adv_o(a_adv), .b_adv_o(b_adv),
        .vld_o(key_vld_o), .err_o(seed_err_o)
    );

    // Keystream bit: parity of the two data register outputs.
    always_comb key_o = a_bit ^ b_bit;

    // R5: a step with control bit 1 leaves the second data register alone.
    a_r5_b_still: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && ctl_bit) |=> $stable(b_state));

    // R6: a step with control bit 0 leaves the first data register alone.
    a_r6_a_still: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && !ctl_bit) |=> $stable(a_state));

    // R4: every enabled step changes the control register.
    a_r4_ctl_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i) |=> !$stable(ctl_state));

endmodule

// File: tb/altstep_keygen_bench.sv
`timescale 1ns/1ps
// Bench: sweeps seeds and compares against an arithmetic model.
module altstep_keygen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0;
    logic [4:0]  seed_ctl_i = '0;
    logic [6:0]  seed_a_i = '0;
    logic [10:0] seed_b_i = '0;
    logic        step_i = 1'b0;
    logic        key_o, key_vld_o, seed_err_o;

    int checks = 0;
    int fails  = 0;
    int m_c, m_a, m_b;

    always #2.5 clk = ~clk;

    altstep_keygen u_altstep_keygen (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .seed_ctl_i(seed_ctl_i),
        .seed_a_i(seed_a_i), .seed_b_i(seed_b_i), .step_i(step_i),
        .key_o(key_o), .key_vld_o(key_vld_o), .seed_err_o(seed_err_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one cycle of inputs, then sample 1 ns after the edge.
    task automatic cycle(input logic ld, input logic st);
        @(negedge clk);
        load_i = ld;
        step_i = st;
        @(posedge clk);
        #1;
    endtask

    // Model one step: R4, R5, R6.
    task automatic model_step();
        int c;
        c = m_c & 1;
        m_c = (m_c >> 1) | (((m_c ^ (m_c >> 3)) & 1) << 4);
        if (c == 1) m_a = (m_a >> 1) | (((m_a ^ (m_a >> 6)) & 1) << 6);
        else        m_b = (m_b >> 1) | (((m_b ^ (m_b >> 9)) & 1) << 10);
    endtask

    task automatic load_seeds(input int c, input int a, input int b, input logic with_step);
        seed_ctl_i = c[4:0];
        seed_a_i   = a[6:0];
        seed_b_i   = b[10:0];
        cycle(1'b1, with_step);
        m_c = (c == 0) ? 1 : c;
        m_a = (a == 0) ? 1 : a;
        m_b = (b == 0) ? 1 : b;
        check("R2 vld after load", key_vld_o, 0);
        check("R2 key after load", key_o, (m_a ^ m_b) & 1);
        check("R3 err flag", seed_err_o, (c == 0 || a == 0 || b == 0) ? 1 : 0);
    endtask

    task automatic run_steps(input int n);
        for (int i = 0; i < n; i++) begin
            cycle(1'b0, 1'b1);
            model_step();
            check("R7 key (R4 R5 R6)", key_o, (m_a ^ m_b) & 1);
            check("R8 vld after step", key_vld_o, 1);
        end
    endtask

    initial begin
        #150000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        cycle(1'b0, 1'b0);
        cycle(1'b0, 1'b0);
        // R1: reset state.
        check("R1 vld", key_vld_o, 0);
        check("R1 err", seed_err_o, 0);
        check("R1 key", key_o, 0);
        rst_n = 1'b1;
        m_c = 1; m_a = 1; m_b = 1;
        run_steps(20);

        // R8 and R9: idle cycles hold key and drop valid.
        begin
            int k;
            k = key_o;
            for (int i = 0; i < 3; i++) begin
                cycle(1'b0, 1'b0);
                check("R8 vld idle", key_vld_o, 0);
                check("R9 key hold", key_o, k);
            end
        end

        // R3: error flag is a single-cycle pulse.
        load_seeds(0, 5, 9, 1'b0);
        cycle(1'b0, 1'b0);
        check("R3 err one cycle", seed_err_o, 0);
        run_steps(40);

        // Sweep all nonzero control seeds (R4 R5 R6 R7).
        for (int c = 1; c < 32; c++) begin
            load_seeds(c, 7'h45, 11'h2A5, 1'b0);
            run_steps(45);
        end

        // Sweep data seeds, with load issued together with step (R2).
        for (int a = 1; a < 128; a += 3) begin
            load_seeds(19, a, (a * 37 + 11) % 2048, 1'b1);
            run_steps(30);
            cycle(1'b0, 1'b0);
            check("R8 vld drop", key_vld_o, 0);
        end

        // Every combination of zero seeds (R3).
        for (int z = 1; z < 8; z++) begin
            load_seeds((z & 1) ? 0 : 13, (z & 2) ? 0 : 77, (z & 4) ? 0 : 1500, 1'b0);
            run_steps(25);
            check("R3 err clear", seed_err_o, 0);
        end

        // Control period of 31 seen through a long run (R4).
        load_seeds(31, 127, 2047, 1'b0);
        run_steps(300);

        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule